// File: doc/BRIEF.md
# Flash Sector Write-Protection Guard

This block sits between a serial-flash command decoder and the array sequencer and decides, one request at a time, whether a page program, a sector erase or a whole-array erase may start. It judges a request by four things. The write-enable latch must be set. A contiguous protected region, sized by a three-bit block-protect field and anchored at the high or low end of the array by a region-select bit, must not cover the target. For single-sector operations, the sector's non-volatile and volatile protection bits must both be 1. A volatile lock governs whether the non-volatile bits can still be changed.

The block also holds the status and configuration bits that these decisions use. A small command port changes them: set latch, clear latch, register write, clear flags, and writes to the per-sector bits and the lock. One cycle after a request, the block returns either a single-cycle start pulse or a single-cycle deny pulse. A denial also records the failure in the status byte. A query port reads back the two protection bits of any sector, so software can confirm its protection state.

Top module: `fpw_guard`

## Requirements
- R1: After reset the status byte reads 0x1C (block-protect field 111, latch 0, both fail flags 0) with the default volatile option, the configuration byte reads 0x00, the lock reads 1, every sector's non-volatile and volatile bits read 1, and neither response output is high.
- R2: Command 0x06 sets the write-enable latch (status bit 1). Command 0x04 clears it.
- R3: Command 0x01 with the latch set copies cmd_data[4:2] into the block-protect field (status bits 4:2) and cmd_data[13] into the region-select bit (configuration bit 5), then clears the latch. With the latch clear, the command changes nothing.
- R4: A request made while the latch is clear, or a request of kind 3, gives no start pulse and no deny pulse and leaves the status byte unchanged.
- R5: A block-protect value v from 1 to 7 protects 4·2^(v-1) sectors of 256. With region-select 0 these are the highest-numbered sectors; with region-select 1 they are the lowest-numbered. A program (kind 0) or sector erase (kind 1) aimed inside the region is denied, and one aimed outside it is granted.
- R6: A whole-array erase (kind 2) with the latch set is granted only when the block-protect field is 000. The per-sector bits do not affect it.
- R7: A program or sector erase aimed at a sector whose non-volatile bit or volatile bit is 0 is denied.
- R8: With the latch set and the lock at 1, command 0xE3 clears the non-volatile bit of cmd_sector and command 0xE4 sets every non-volatile bit to 1. Both commands clear the latch.
- R9: With the latch set, command 0xA6 clears the lock, and only reset sets it again. While the lock is 0, commands 0xE3 and 0xE4 leave every non-volatile bit unchanged, clear the latch, and set the program-fail flag (0xE3) or the erase-fail flag (0xE4).
- R10: With the latch set, command 0xE1 writes cmd_data[0] into the volatile bit of cmd_sector and clears the latch, whatever the lock value.
- R11: One cycle after a request that passes the latch test, exactly one of op_start and op_deny pulses for one cycle, and the latch is cleared. A denied program sets status bit 6, and a denied erase of either kind sets status bit 5.
- R12: Command 0x30 clears status bits 5 and 6, needs no latch, and leaves the latch unchanged.
- R13: When op_valid and cmd_valid are high in the same cycle, the command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Register or protection command present this cycle |
| cmd_op | input | 8 | Command code |
| cmd_sector | input | SECT_W | Sector index used by per-sector commands |
| cmd_data | input | 16 | Command payload: status image in [7:0], configuration image in [15:8] |
| op_valid | input | 1 | Array operation request present this cycle |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 whole-array erase, 3 reserved |
| op_sector | input | SECT_W | Target sector of the request |
| qry_sector | input | SECT_W | Sector whose protection bits are shown on the query outputs |
| op_start | output | 1 | Request granted, one-cycle pulse |
| op_deny | output | 1 | Request refused, one-cycle pulse |
| status_o | output | 8 | Status byte |
| config_o | output | 8 | Configuration byte |
| lock_o | output | 1 | Lock state for the non-volatile bits |
| qry_ppb | output | 1 | Non-volatile protection bit of qry_sector |
| qry_dyb | output | 1 | Volatile protection bit of qry_sector |

## Verification
The hardest state to reach from the ports is a sector that is cleared in the non-volatile bits while the lock is already 0. Only a test that uses the correct order reaches it: clear the sector's bit first, then drop the lock, then try a group erase, which must fail and leave the bit at 0. The region decoder needs the next most care. Each of the seven protect sizes is combined with both anchor positions, and every pair is tested at the sectors just inside and just outside each region edge, so an off-by-one in the size exponent or the anchoring shows up as a wrong pulse.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

   typedef enum logic [1:0] {
      OPK_PROG   = 2'd0,
      OPK_SERASE = 2'd1,
      OPK_BERASE = 2'd2,
      OPK_RSVD   = 2'd3
   } op_kind_e;

   localparam logic [7:0] CMD_WREN     = 8'h06;
   localparam logic [7:0] CMD_WRDI     = 8'h04;
   localparam logic [7:0] CMD_WRREG    = 8'h01;
   localparam logic [7:0] CMD_CLRFLG   = 8'h30;
   localparam logic [7:0] CMD_NV_CLR   = 8'hE3;
   localparam logic [7:0] CMD_NV_ERASE = 8'hE4;
   localparam logic [7:0] CMD_VOL_WR   = 8'hE1;
   localparam logic [7:0] CMD_LOCK_CLR = 8'hA6;

   localparam int SR_WEL  = 1;
   localparam int SR_BP_L = 2;
   localparam int SR_EERR = 5;
   localparam int SR_PERR = 6;
   localparam int CR_TB   = 5;

   // smallest region is 1/64 of the array
   localparam int MIN_FRAC_LOG = 6;
   localparam int BP_W         = 3;

endpackage

// File: rtl/fpw_range.sv
module fpw_range
   import fpw_pkg::*;
#(
   parameter int SECT_W = 8
) (
   input  logic [BP_W-1:0]   bp,
   input  logic              tb_low,
   input  logic [SECT_W-1:0] sector,
   output logic              hit
);
   localparam int BASE = SECT_W - (1 << BP_W) + 1;
   localparam int EW   = $clog2(SECT_W + 1);

   logic [EW-1:0]     expo;
   logic [SECT_W-1:0] probe;
   logic [SECT_W-1:0] rest;

   always_comb begin
      expo  = EW'(BASE) + EW'(bp);
      probe = tb_low ? sector : ~sector;
      rest  = probe >> expo;
      hit   = (bp != '0) && (rest == '0);
   end

endmodule

// File: rtl/fpw_regs.sv
module fpw_regs
   import fpw_pkg::*;
#(
   parameter bit BP_VOLATILE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_wel,
   input  logic            clr_wel,
   input  logic            wr_regs,
   input  logic [BP_W-1:0] new_bp,
   input  logic            new_tb,
   input  logic            set_perr,
   input  logic            set_eerr,
   input  logic            clr_flags,
   input  logic            clr_lock,
   output logic            wel,
   output logic [BP_W-1:0] bp,
   output logic            tb_low,
   output logic            perr,
   output logic            eerr,
   output logic            lock
);
   logic [BP_W-1:0] bp_rst;

   if (BP_VOLATILE) begin : g_bp_vol
      assign bp_rst = '1;
   end else begin : g_bp_nv
      assign bp_rst = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wel <= 1'b0;
      end else if (clr_wel) begin
         wel <= 1'b0;
      end else if (set_wel) begin
         wel <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bp     <= bp_rst;
         tb_low <= 1'b0;
      end else if (wr_regs) begin
         bp     <= new_bp;
         tb_low <= new_tb;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         perr <= 1'b0;
         eerr <= 1'b0;
      end else begin
         if (set_perr)       perr <= 1'b1;
         else if (clr_flags) perr <= 1'b0;
         if (set_eerr)       eerr <= 1'b1;
         else if (clr_flags) eerr <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        lock <= 1'b1;
      else if (clr_lock) lock <= 1'b0;
   end

endmodule

// File: rtl/fpw_sector_bits.sv
module fpw_sector_bits #(
   parameter int SECT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nv_clr,
   input  logic              nv_erase,
   input  logic              vol_wr,
   input  logic              vol_val,
   input  logic [SECT_W-1:0] wr_sector,
   input  logic [SECT_W-1:0] rd_a,
   input  logic [SECT_W-1:0] rd_b,
   output logic              nv_a,
   output logic              vol_a,
   output logic              nv_b,
   output logic              vol_b
);
   localparam int NSECT = 1 << SECT_W;

   logic [NSECT-1:0] nv_bits;
   logic [NSECT-1:0] vol_bits;

   for (genvar g = 0; g < NSECT; g++) begin : g_sect
      logic sel;
      assign sel = (wr_sector == SECT_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            nv_bits[g] <= 1'b1;
         end else if (nv_erase) begin
            nv_bits[g] <= 1'b1;
         end else if (nv_clr && sel) begin
            nv_bits[g] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vol_bits[g] <= 1'b1;
         end else if (vol_wr && sel) begin
            vol_bits[g] <= vol_val;
         end
      end
   end

   assign nv_a  = nv_bits[rd_a];
   assign vol_a = vol_bits[rd_a];
   assign nv_b  = nv_bits[rd_b];
   assign vol_b = vol_bits[rd_b];

endmodule

// File: rtl/fpw_guard.sv
module fpw_guard
   import fpw_pkg::*;
#(
   parameter int SECT_W      = 8,
   parameter bit BP_VOLATILE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_op,
   input  logic [SECT_W-1:0] cmd_sector,
   input  logic [15:0]       cmd_data,
   input  logic              op_valid,
   input  logic [1:0]        op_kind,
   input  logic [SECT_W-1:0] op_sector,
   input  logic [SECT_W-1:0] qry_sector,
   output logic              op_start,
   output logic              op_deny,
   output logic [7:0]        status_o,
   output logic [7:0]        config_o,
   output logic              lock_o,
   output logic              qry_ppb,
   output logic              qry_dyb
);
   if (SECT_W < MIN_FRAC_LOG || SECT_W > 12) begin : g_bad_sect_w
      $error("fpw_guard: SECT_W must lie in 6..12");
   end

   logic            wel, tb_low, perr, eerr, lock;
   logic [BP_W-1:0] bp;
   logic            nv_tgt, vol_tgt, in_region;

   logic cmd_go, is_wren, is_wrdi, is_wrreg, is_clr, is_nvclr;
   logic is_nverase, is_volwr, is_lockclr;
   logic nv_ok, nv_bad;
   logic op_act, blocked, start_d, deny_d;
   logic set_perr, set_eerr, clr_wel;
   op_kind_e kind;

   assign kind = op_kind_e'(op_kind);

   fpw_range #(.SECT_W(SECT_W)) u_range (
      .bp     (bp),
      .tb_low (tb_low),
      .sector (op_sector),
      .hit    (in_region)
   );

   fpw_sector_bits #(.SECT_W(SECT_W)) u_bits (
      .clk       (clk),
      .rst_n     (rst_n),
      .nv_clr    (is_nvclr && nv_ok),
      .nv_erase  (is_nverase && nv_ok),
      .vol_wr    (is_volwr),
      .vol_val   (cmd_data[0]),
      .wr_sector (cmd_sector),
      .rd_a      (op_sector),
      .rd_b      (qry_sector),
      .nv_a      (nv_tgt),
      .vol_a     (vol_tgt),
      .nv_b      (qry_ppb),
      .vol_b     (qry_dyb)
   );

   always_comb begin
      cmd_go     = cmd_valid && !op_valid;
      is_wren    = cmd_go && (cmd_op == CMD_WREN);
      is_wrdi    = cmd_go && (cmd_op == CMD_WRDI);
      is_clr     = cmd_go && (cmd_op == CMD_CLRFLG);
      is_wrreg   = cmd_go && wel && (cmd_op == CMD_WRREG);
      is_nvclr   = cmd_go && wel && (cmd_op == CMD_NV_CLR);
      is_nverase = cmd_go && wel && (cmd_op == CMD_NV_ERASE);
      is_volwr   = cmd_go && wel && (cmd_op == CMD_VOL_WR);
      is_lockclr = cmd_go && wel && (cmd_op == CMD_LOCK_CLR);
      nv_ok      = lock;
      nv_bad     = (is_nvclr || is_nverase) && !nv_ok;

      op_act  = op_valid && wel && (kind != OPK_RSVD);
      if (kind == OPK_BERASE) blocked = (bp != '0);
      else                    blocked = in_region || !nv_tgt || !vol_tgt;
      start_d = op_act && !blocked;
      deny_d  = op_act && blocked;

      set_perr = (deny_d && kind == OPK_PROG) || (nv_bad && is_nvclr);
      set_eerr = (deny_d && kind != OPK_PROG) || (nv_bad && is_nverase);
      clr_wel  = op_act || is_wrdi || is_wrreg || is_nvclr || is_nverase
                 || is_volwr || is_lockclr;
   end

   fpw_regs #(.BP_VOLATILE(BP_VOLATILE)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_wel   (is_wren),
      .clr_wel   (clr_wel),
      .wr_regs   (is_wrreg),
      .new_bp    (cmd_data[SR_BP_L +: BP_W]),
      .new_tb    (cmd_data[8 + CR_TB]),
      .set_perr  (set_perr),
      .set_eerr  (set_eerr),
      .clr_flags (is_clr),
      .clr_lock  (is_lockclr),
      .wel       (wel),
      .bp        (bp),
      .tb_low    (tb_low),
      .perr      (perr),
      .eerr      (eerr),
      .lock      (lock)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_start <= 1'b0;
         op_deny  <= 1'b0;
      end else begin
         op_start <= start_d;
         op_deny  <= deny_d;
      end
   end

   always_comb begin
      status_o                      = '0;
      status_o[SR_WEL]              = wel;
      status_o[SR_BP_L +: BP_W]     = bp;
      status_o[SR_EERR]             = eerr;
      status_o[SR_PERR]             = perr;
      config_o                      = '0;
      config_o[CR_TB]               = tb_low;
   end

   assign lock_o = lock;

   logic unused_data;
   assign unused_data = ^{cmd_data[15:14], cmd_data[12:8], cmd_data[7:5], cmd_data[1]};

endmodule

// File: rtl/fpw_guard_chk.sv
module fpw_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [7:0] cmd_op,
   input logic       op_valid,
   input logic [1:0] op_kind,
   input logic       op_start,
   input logic       op_deny,
   input logic [7:0] status_o,
   input logic       lock_o
);
   // R11
   one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_start && op_deny));

   // R11
   start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start || op_deny) |-> ($past(status_o[1]) && !status_o[1]));

   // R11
   prog_deny_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_deny && $past(op_kind) == 2'd0) |-> status_o[6]);

   // R6
   bulk_bp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && $past(op_kind) == 2'd2) |-> ($past(status_o[4:2]) == 3'b000));

   // R9
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_o |=> !lock_o);

   // R12
   clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !op_valid && cmd_op == 8'h30) |=> (status_o[6:5] == 2'b00));

   // R4
   no_wel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !status_o[1]) |=> (!op_start && !op_deny));

endmodule

bind fpw_guard fpw_guard_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .op_valid  (op_valid),
   .op_kind   (op_kind),
   .op_start  (op_start),
   .op_deny   (op_deny),
   .status_o  (status_o),
   .lock_o    (lock_o)
);

// File: tb/fpw_guard_test.sv
module fpw_guard_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_op = '0;
   logic [7:0] cmd_sector = '0;
   logic [15:0] cmd_data = '0;
   logic       op_valid = 1'b0;
   logic [1:0] op_kind = '0;
   logic [7:0] op_sector = '0;
   logic [7:0] qry_sector = '0;
   logic       op_start, op_deny, lock_o, qry_ppb, qry_dyb;
   logic [7:0] status_o, config_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   fpw_guard uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_sector(cmd_sector), .cmd_data(cmd_data), .op_valid(op_valid),
      .op_kind(op_kind), .op_sector(op_sector), .qry_sector(qry_sector),
      .op_start(op_start), .op_deny(op_deny), .status_o(status_o),
      .config_o(config_o), .lock_o(lock_o), .qry_ppb(qry_ppb), .qry_dyb(qry_dyb)
   );

   task automatic check(string req, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_cmd(logic [7:0] op, int sec, logic [15:0] data);
      cmd_valid = 1'b1; cmd_op = op; cmd_sector = 8'(sec); cmd_data = data;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic do_op(int kind, int sec, output logic s, output logic d);
      op_valid = 1'b1; op_kind = 2'(kind); op_sector = 8'(sec);
      @(negedge clk);
      s = op_start; d = op_deny;
      op_valid = 1'b0;
   endtask

   task automatic query(int sec, output logic p, output logic v);
      qry_sector = 8'(sec);
      #1;
      p = qry_ppb; v = qry_dyb;
   endtask

   task automatic set_regs(int bpv, int tb);
      do_cmd(8'h06, 0, '0);
      do_cmd(8'h01, 0, 16'((tb << 13) | (bpv << 2)));
   endtask

   function automatic bit prot(int v, int tb, int s);
      int cnt;
      if (v == 0) return 1'b0;
      cnt = 4 << (v - 1);
      return tb ? (s < cnt) : (s >= 256 - cnt);
   endfunction

   task automatic t_reset;
      logic p, v;
      check("R1", "status", status_o, 8'h1C);
      check("R1", "config", config_o, 0);
      check("R1", "lock", lock_o, 1);
      check("R1", "responses", {op_start, op_deny}, 0);
      query(0, p, v);   check("R1", "bits sector 0", {p, v}, 3);
      query(255, p, v); check("R1", "bits sector 255", {p, v}, 3);
   endtask

   task automatic t_wel;
      do_cmd(8'h06, 0, '0);
      check("R2", "latch after set", status_o[1], 1);
      do_cmd(8'h04, 0, '0);
      check("R2", "latch after clear", status_o[1], 0);
   endtask

   task automatic t_no_wel;
      logic s, d;
      do_cmd(8'h01, 0, 16'h2000);
      check("R3", "status after unlatched write", status_o, 8'h1C);
      check("R3", "config after unlatched write", config_o, 0);
      do_op(0, 0, s, d);
      check("R4", "unlatched request response", {s, d}, 0);
      check("R4", "unlatched request status", status_o, 8'h1C);
      do_cmd(8'h06, 0, '0);
      do_op(3, 0, s, d);
      check("R4", "reserved kind response", {s, d}, 0);
      check("R4", "reserved kind status", status_o, 8'h1E);
      do_cmd(8'h04, 0, '0);
   endtask

   task automatic t_wrr;
      set_regs(0, 1);
      check("R3", "status after write", status_o, 8'h00);
      check("R3", "config after write", config_o, 8'h20);
      set_regs(5, 0);
      check("R3", "bp field", status_o[4:2], 5);
   endtask

   task automatic t_range;
      logic s, d;
      for (int v = 1; v < 8; v++) begin
         for (int tb = 0; tb < 2; tb++) begin
            int cnt;
            int probes[6];
            cnt = 4 << (v - 1);
            probes = '{0, 255, cnt - 1, cnt, 255 - cnt, 256 - cnt};
            set_regs(v, tb);
            for (int i = 0; i < 6; i++) begin
               int sec;
               int kind;
               bit exp_p;
               sec = probes[i];
               if (sec < 0 || sec > 255) continue;
               kind = i % 2;
               exp_p = prot(v, tb, sec);
               do_cmd(8'h06, 0, '0);
               do_op(kind, sec, s, d);
               check("R5", $sformatf("v%0d tb%0d sector %0d start/deny", v, tb, sec),
                     {s, d}, exp_p ? 1 : 2);
               check("R11", "flags and latch after response",
                     {status_o[6:5], status_o[1]},
                     exp_p ? (kind == 0 ? 4 : 2) : 0);
               do_cmd(8'h30, 0, '0);
            end
         end
      end
   endtask

   task automatic t_bulk;
      logic s, d;
      set_regs(0, 0);
      do_cmd(8'h06, 0, '0);
      do_op(2, 0, s, d);
      check("R6", "bulk erase with bp 0", {s, d}, 2);
      set_regs(1, 0);
      do_cmd(8'h06, 0, '0);
      do_op(2, 0, s, d);
      check("R6", "bulk erase with bp 1", {s, d}, 1);
      check("R11", "erase fail flag and latch", {status_o[6:5], status_o[1]}, 2);
      do_cmd(8'h06, 0, '0);
      do_cmd(8'h30, 0, '0);
      check("R12", "flags cleared latch kept", {status_o[6:5], status_o[1]}, 1);
      do_cmd(8'h04, 0, '0);
   endtask

   task automatic t_sector_bits;
      logic s, d, p, v;
      set_regs(0, 0);
      do_cmd(8'h06, 0, '0);
      do_cmd(8'hE3, 10, '0);
      query(10, p, v); check("R8", "nv bit of sector 10 cleared", p, 0);
      query(11, p, v); check("R8", "nv bit of sector 11 kept", p, 1);
      check("R8", "latch after nv clear", status_o[1], 0);
      do_cmd(8'h06, 0, '0);
      do_op(0, 10, s, d);
      check("R7", "program into nv-protected sector", {s, d}, 1);
      do_cmd(8'h06, 0, '0);
      do_op(0, 11, s, d);
      check("R7", "program into open sector", {s, d}, 2);
      do_cmd(8'h06, 0, '0);
      do_cmd(8'hE1, 20, 16'h0000);
      query(20, p, v); check("R10", "vol bit of sector 20", v, 0);
      check("R10", "latch after vol write", status_o[1], 0);
      do_cmd(8'h06, 0, '0);
      do_op(1, 20, s, d);
      check("R7", "erase of vol-protected sector", {s, d}, 1);
      do_cmd(8'h06, 0, '0);
      do_op(2, 0, s, d);
      check("R6", "bulk erase ignores sector bits", {s, d}, 2);
      do_cmd(8'h06, 0, '0);
      do_cmd(8'hE1, 20, 16'h0001);
      do_cmd(8'h06, 0, '0);
      do_op(1, 20, s, d);
      check("R10", "erase after vol bit restored", {s, d}, 2);
      do_cmd(8'h06, 0, '0);
      do_cmd(8'hE4, 0, '0);
      query(10, p, v); check("R8", "nv group erase", p, 1);
      do_cmd(8'h30, 0, '0);
   endtask

   task automatic t_collision;
      logic s, d;
      cmd_valid = 1'b1; cmd_op = 8'h06;
      op_valid = 1'b1; op_kind = 2'd0; op_sector = 8'd50;
      @(negedge clk);
      s = op_start; d = op_deny;
      cmd_valid = 1'b0; op_valid = 1'b0;
      check("R13", "latch set ignored during request", status_o[1], 0);
      check("R13", "request without latch", {s, d}, 0);
   endtask

   task automatic t_lock;
      logic p, v;
      do_cmd(8'h06, 0, '0);
      do_cmd(8'hE3, 40, '0);
      do_cmd(8'h06, 0, '0);
      do_cmd(8'hA6, 0, '0);
      check("R9", "lock cleared", lock_o, 0);
      do_cmd(8'h06, 0, '0);
      do_cmd(8'hE3, 30, '0);
      query(30, p, v); check("R9", "nv clear blocked", p, 1);
      check("R9", "program flag and latch", {status_o[6], status_o[1]}, 2);
      do_cmd(8'h06, 0, '0);
      do_cmd(8'hE4, 0, '0);
      query(40, p, v); check("R9", "nv erase blocked", p, 0);
      check("R9", "erase flag and latch", {status_o[5], status_o[1]}, 2);
      do_cmd(8'h06, 0, '0);
      do_cmd(8'hE1, 60, 16'h0000);
      query(60, p, v); check("R10", "vol write under lock", v, 0);
      do_cmd(8'h06, 0, '0);
      do_cmd(8'h04, 0, '0);
      check("R9", "lock still cleared", lock_o, 0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "lock after reset", lock_o, 1);
      check("R1", "status after reset", status_o, 8'h1C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wel();
      t_no_wel();
      t_wrr();
      t_range();
      t_bulk();
      t_sector_bits();
      t_collision();
      t_lock();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule